// File: doc/BRIEF.md
# Voice Recorder Control Sequencer

This block is the digital control state machine of a single-chip message recorder and player. Three active-low push-buttons drive it: a record button, a play button that acts on its press alone (edge play), and a play button that keeps playback going only while held (level play). The block passes every button through a two-flop synchronizer and watches the synchronized levels for falling and rising edges. Record always wins over playback. When record is released, its high level must stay stable for a debounce window before the cycle is closed. The block issues start and stop strobes plus a start address to a storage address unit. That unit reports end-of-message and end-of-memory events back as single-cycle pulses.

The eight address lines double as mode lines. When the two top bits are both high, the lines select modes rather than an address, and the start address becomes zero. Bit 3 high in that mode selects looping, where each end of message restarts playback from the start. The block drives a record LED (active low), a speaker high-impedance control, a speaker drive enable and a standby request. Every duration is a count of a sample-rate tick enable (nominally 6.4 kHz), so the timing does not depend on the system clock.

Top module: `vrec_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in standby: led_n=1, pwr_down=1, spk_hiz=0, spk_drive=0, and all strobes low.
- R2: A falling edge on the synchronized record input gives a one-cycle start_rec and loads start_addr from addr. While recording, led_n=0, spk_hiz=1 and pwr_down=0.
- R3: A record falling edge during playback ends playback at once: start_rec pulses, spk_drive drops and spk_hiz rises in the same cycle.
- R4: A record release closes the cycle only after the record input has stayed high for DB_TICKS ticks. The LED stays low until then. A low glitch in that window resumes recording with no new start_rec. When the window completes, stop_str pulses once and the block enters standby.
- R5: mem_end during recording pulses stop_str and turns the LED off. The block waits for release plus debounce, then enters standby with no second stop_str.
- R6: A falling edge on play_edge_n gives start_play, loads start_addr and sets spk_drive=1. Raising play_edge_n has no effect. Without looping, mem_end ends playback with stop_str and goes straight to standby.
- R7: During playback, a rising edge on the synchronized play_lvl_n pulses stop_str and enters standby.
- R8: eom_hit during non-looping playback pulses stop_str and drives led_n low for EOM_TICKS ticks. The block then enters standby.
- R9: When addr[7] and addr[6] are both 1, start_addr is 0. If addr[3] is also 1 at a play start, each eom_hit or mem_end gives a new start_play with start_addr 0, with no stop_str, and playback continues.
- R10: A looping playback, whether started by the edge button or held by the level button, stops with stop_str on the rising edge of play_lvl_n.
- R11: A play falling edge during the end-of-message LED pulse starts a new playback at once.
- R12: pwr_down is high only in standby. spk_hiz is high only in record states. spk_drive is high only during playback. spk_hiz and spk_drive are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate tick enable used for all durations |
| rec_n | input | 1 | Record button, active low |
| play_edge_n | input | 1 | Edge play button, active low |
| play_lvl_n | input | 1 | Level play button, active low |
| addr | input | AW | Start address or mode lines |
| eom_hit | input | 1 | End-of-message marker reached (storage unit) |
| mem_end | input | 1 | End of memory reached (storage unit) |
| led_n | output | 1 | Record LED, active low |
| pwr_down | output | 1 | Standby request |
| spk_hiz | output | 1 | Speaker output to high impedance |
| spk_drive | output | 1 | Speaker drive enable; speaker held low when 0 |
| start_rec | output | 1 | One-cycle record start strobe |
| start_play | output | 1 | One-cycle playback start strobe |
| stop_str | output | 1 | One-cycle cycle-end strobe |
| start_addr | output | AW | Start address issued with a start strobe |

## Verification
Record is tried three ways: released cleanly, released with a one-cycle bounce inside the debounce window, and held past memory full. These patterns separate a debounce that restarts from one that ignores glitches, and a full-memory stop from a release stop. Play is tried with a short edge press, a short level press, and a held level press. Each of these runs against eom_hit, mem_end and level release, which separates the two termination rules. The mode address values 0xC8 and 0xC0, set against plain addresses, show whether the mode decode zeroes the start address and whether looping restarts without stopping. A record press during play, and a play press during the LED pulse, exercise the precedence rules.

// File: rtl/vrec_ctrl.sv
module vrec_ctrl #(
  parameter int AW        = 8,
  parameter int LOOP_BIT  = 3,
  parameter int DB_TICKS  = 320,
  parameter int EOM_TICKS = 100,
  localparam int MAXT     = (DB_TICKS > EOM_TICKS) ? DB_TICKS : EOM_TICKS,
  localparam int CW       = $clog2(MAXT) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rec_n,
  input  logic          play_edge_n,
  input  logic          play_lvl_n,
  input  logic [AW-1:0] addr,
  input  logic          eom_hit,
  input  logic          mem_end,
  output logic          led_n,
  output logic          pwr_down,
  output logic          spk_hiz,
  output logic          spk_drive,
  output logic          start_rec,
  output logic          start_play,
  output logic          stop_str,
  output logic [AW-1:0] start_addr
);

  typedef enum logic [2:0] {S_IDLE, S_REC, S_DB, S_FULL, S_PLAY, S_EOMP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          full, loop_q;
  logic [2:0]    s1, s2, pv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '1;
      s2 <= '1;
      pv <= '1;
    end else begin
      s1 <= {rec_n, play_edge_n, play_lvl_n};
      s2 <= s1;
      pv <= s2;
    end
  end

  logic [2:0]    falls;
  logic          lvl_rise, mode_sel, loop_req;
  logic [AW-1:0] addr_eff;

  assign falls    = pv & ~s2;
  assign lvl_rise = ~pv[0] & s2[0];
  assign mode_sel = addr[AW-1] & addr[AW-2];
  assign loop_req = mode_sel & addr[LOOP_BIT];
  assign addr_eff = mode_sel ? '0 : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      full       <= 1'b0;
      loop_q     <= 1'b0;
      start_rec  <= 1'b0;
      start_play <= 1'b0;
      stop_str   <= 1'b0;
      start_addr <= '0;
    end else begin
      start_rec  <= 1'b0;
      start_play <= 1'b0;
      stop_str   <= 1'b0;
      if (falls[2] && st != S_DB) begin
        st         <= S_REC;
        full       <= 1'b0;
        loop_q     <= 1'b0;
        start_rec  <= 1'b1;
        start_addr <= addr_eff;
      end else begin
        case (st)
          S_REC: begin
            if (mem_end) begin
              st       <= S_FULL;
              full     <= 1'b1;
              stop_str <= 1'b1;
            end else if (s2[2]) begin
              st  <= S_DB;
              cnt <= '0;
            end
          end
          S_FULL: begin
            if (s2[2]) begin
              st  <= S_DB;
              cnt <= '0;
            end
          end
          S_DB: begin
            if (!s2[2]) begin
              st <= full ? S_FULL : S_REC;
            end else if (tick) begin
              if (cnt == CW'(DB_TICKS - 1)) begin
                st       <= S_IDLE;
                stop_str <= ~full;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_PLAY: begin
            if (lvl_rise) begin
              st       <= S_IDLE;
              stop_str <= 1'b1;
            end else if (eom_hit || mem_end) begin
              if (loop_q) begin
                start_play <= 1'b1;
                start_addr <= '0;
              end else if (eom_hit) begin
                st       <= S_EOMP;
                cnt      <= '0;
                stop_str <= 1'b1;
              end else begin
                st       <= S_IDLE;
                stop_str <= 1'b1;
              end
            end
          end
          default: begin
            if (falls[1] || falls[0]) begin
              st         <= S_PLAY;
              start_play <= 1'b1;
              start_addr <= addr_eff;
              loop_q     <= loop_req;
            end else if (st == S_EOMP && tick) begin
              if (cnt == CW'(EOM_TICKS - 1)) st <= S_IDLE;
              else cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign led_n     = ~((st == S_REC) || (st == S_DB && !full) || (st == S_EOMP));
  assign pwr_down  = (st == S_IDLE);
  assign spk_hiz   = (st == S_REC) || (st == S_DB) || (st == S_FULL);
  assign spk_drive = (st == S_PLAY);

  AST_RESET_STANDBY: assert property (@(posedge clk) rst |=> (led_n && pwr_down)); // R1
  AST_REC_START_LED: assert property (@(posedge clk) disable iff (rst)
    start_rec |-> (!led_n && spk_hiz && !pwr_down)); // R2
  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    !(start_rec && start_play)); // R3
  AST_PLAY_START_DRIVE: assert property (@(posedge clk) disable iff (rst)
    start_play |-> (spk_drive && !pwr_down)); // R6
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    stop_str |-> !spk_drive); // R7
  AST_MODE_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    ((start_rec || start_play) && start_addr != '0) |-> !($past(addr[AW-1]) && $past(addr[AW-2]))); // R9
  AST_SPK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(spk_hiz && spk_drive)); // R12
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (led_n && !spk_hiz && !spk_drive)); // R12

endmodule

// File: tb/vrec_ctrl_tb_top.sv
module vrec_ctrl_tb_top;
  localparam int DB  = 6;
  localparam int EOM = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic rec_n = 1'b1, play_edge_n = 1'b1, play_lvl_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic eom_hit = 1'b0, mem_end = 1'b0;
  logic led_n, pwr_down, spk_hiz, spk_drive, start_rec, start_play, stop_str;
  logic [7:0] start_addr;

  vrec_ctrl #(.DB_TICKS(DB), .EOM_TICKS(EOM)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rec_n(rec_n), .play_edge_n(play_edge_n),
    .play_lvl_n(play_lvl_n), .addr(addr), .eom_hit(eom_hit), .mem_end(mem_end),
    .led_n(led_n), .pwr_down(pwr_down), .spk_hiz(spk_hiz), .spk_drive(spk_drive),
    .start_rec(start_rec), .start_play(start_play), .stop_str(stop_str),
    .start_addr(start_addr));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int sr_cnt = 0, sp_cnt = 0, ss_cnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: mode 0 standby, 1 record, 2 release window,
  // 3 memory full, 4 playing, 5 end-of-message pulse
  int   m_mode, m_cnt;
  bit   m_full, m_loop, m_sr, m_sp, m_ss;
  bit   [7:0] m_addr;
  bit   [2:0] h1, h2, h3;

  always @(posedge clk) begin
    bit [2:0] f;
    bit rise_l, msel;
    bit [7:0] eff;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_full = 0; m_loop = 0;
      m_sr = 0; m_sp = 0; m_ss = 0; m_addr = 0;
      h1 = 3'b111; h2 = 3'b111; h3 = 3'b111;
    end else begin
      f = h3 & ~h2;
      rise_l = !h3[0] && h2[0];
      msel = addr[7] && addr[6];
      eff = msel ? 8'h00 : addr;
      m_sr = 0; m_sp = 0; m_ss = 0;
      if (f[2] && m_mode != 2) begin
        m_mode = 1; m_full = 0; m_loop = 0; m_sr = 1; m_addr = eff;
      end else if (m_mode == 1) begin
        if (mem_end) begin m_mode = 3; m_full = 1; m_ss = 1; end
        else if (h2[2]) begin m_mode = 2; m_cnt = 0; end
      end else if (m_mode == 3) begin
        if (h2[2]) begin m_mode = 2; m_cnt = 0; end
      end else if (m_mode == 2) begin
        if (!h2[2]) m_mode = m_full ? 3 : 1;
        else if (tick) begin
          m_cnt++;
          if (m_cnt == DB) begin m_mode = 0; m_ss = !m_full; end
        end
      end else if (m_mode == 4) begin
        if (rise_l) begin m_mode = 0; m_ss = 1; end
        else if (eom_hit || mem_end) begin
          if (m_loop) begin m_sp = 1; m_addr = 0; end
          else if (eom_hit) begin m_mode = 5; m_cnt = 0; m_ss = 1; end
          else begin m_mode = 0; m_ss = 1; end
        end
      end else begin
        if (f[1] || f[0]) begin
          m_mode = 4; m_sp = 1; m_addr = eff; m_loop = msel && addr[3];
        end else if (m_mode == 5 && tick) begin
          m_cnt++;
          if (m_cnt == EOM) m_mode = 0;
        end
      end
      h3 = h2; h2 = h1; h1 = {rec_n, play_edge_n, play_lvl_n};
    end
  end

  always @(negedge clk) begin
    logic [14:0] exp_v, act_v;
    cycles++;
    tick <= ~tick;
    exp_v = {!(m_mode == 1 || (m_mode == 2 && !m_full) || m_mode == 5), m_mode == 0,
             m_mode inside {1, 2, 3}, m_mode == 4, m_sr, m_sp, m_ss, m_addr};
    act_v = {led_n, pwr_down, spk_hiz, spk_drive, start_rec, start_play, stop_str, start_addr};
    if (!rst) begin
      chk("R12 model", 32'(act_v), 32'(exp_v));
      sr_cnt += start_rec; sp_cnt += start_play; ss_cnt += stop_str;
    end
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    step(4);
    rst = 1'b0;
    step(1);
    chk("R1 led", led_n, 1); chk("R1 pwr", pwr_down, 1);
    chk("R1 hiz", spk_hiz, 0); chk("R1 strobes", {start_rec, start_play, stop_str}, 0);

    // R2 record start, R4 bounce then debounce
    addr = 8'h15; rec_n = 0; step(3);
    chk("R2 start_rec", start_rec, 1); chk("R2 addr", start_addr, 8'h15);
    chk("R2 led", led_n, 0); chk("R2 hiz", spk_hiz, 1);
    step(5); n0 = ss_cnt;
    rec_n = 1; step(5);
    chk("R4 led held", led_n, 0);
    rec_n = 0; step(1); rec_n = 1; step(6);
    chk("R4 no restart", sr_cnt, 1); chk("R4 led", led_n, 0);
    step(40);
    chk("R4 standby", pwr_down, 1); chk("R4 led off", led_n, 1);
    chk("R4 one stop", ss_cnt, n0 + 1);

    // R5 memory full
    addr = 8'h00; rec_n = 0; step(6);
    mem_end = 1; step(1); mem_end = 0;
    chk("R5 stop", stop_str, 1); chk("R5 led", led_n, 1); chk("R5 not standby", pwr_down, 0);
    n0 = ss_cnt + 1;
    step(4); rec_n = 1; step(40);
    chk("R5 standby", pwr_down, 1); chk("R5 no 2nd stop", ss_cnt, n0);

    // R6 edge play, R8 end-of-message pulse
    addr = 8'h22; play_edge_n = 0; step(3);
    chk("R6 start_play", start_play, 1); chk("R6 addr", start_addr, 8'h22);
    chk("R6 drive", spk_drive, 1);
    step(2); play_edge_n = 1; step(10);
    chk("R6 edge release ignored", spk_drive, 1);
    eom_hit = 1; step(1); eom_hit = 0;
    chk("R8 stop", stop_str, 1); chk("R8 led pulse", led_n, 0); chk("R8 drive off", spk_drive, 0);
    step(2 * EOM + 4);
    chk("R8 led end", led_n, 1); chk("R8 standby", pwr_down, 1);

    // R6 mem_end ends edge play
    play_edge_n = 0; step(3); play_edge_n = 1; step(3);
    mem_end = 1; step(1); mem_end = 0;
    chk("R6 mem_end stop", stop_str, 1); chk("R6 standby", pwr_down, 1); chk("R6 led", led_n, 1);

    // R7 level play released
    play_lvl_n = 0; step(3);
    chk("R7 drive", spk_drive, 1);
    step(8); play_lvl_n = 1; step(3);
    chk("R7 stop", stop_str, 1); chk("R7 standby", pwr_down, 1);
    step(3);

    // R9 looping by edge, R10 level pulse stops it
    addr = 8'hC8; play_edge_n = 0; step(3);
    chk("R9 mode addr", start_addr, 0); chk("R9 play", start_play, 1);
    step(1); play_edge_n = 1; step(4);
    n0 = ss_cnt;
    eom_hit = 1; step(1); eom_hit = 0;
    chk("R9 restart", start_play, 1); chk("R9 still playing", spk_drive, 1);
    step(3);
    mem_end = 1; step(1); mem_end = 0;
    chk("R9 restart mem_end", start_play, 1); chk("R9 no stop", ss_cnt, n0);
    step(3);
    play_lvl_n = 0; step(1); play_lvl_n = 1; step(3);
    chk("R10 stop", stop_str, 1); chk("R10 standby", pwr_down, 1);
    step(3);

    // R10 looping held by level button
    play_lvl_n = 0; step(5);
    eom_hit = 1; step(1); eom_hit = 0;
    chk("R10 loop held", spk_drive, 1);
    step(4); play_lvl_n = 1; step(3);
    chk("R10 level release stop", stop_str, 1);
    step(3);

    // R9 mode on record
    addr = 8'hC0; rec_n = 0; step(3);
    chk("R9 rec mode addr", start_addr, 0);
    step(3); rec_n = 1; step(40);

    // R3 record pre-empts play
    addr = 8'h05; play_edge_n = 0; step(3); play_edge_n = 1; step(4);
    chk("R3 playing", spk_drive, 1);
    rec_n = 0; step(3);
    chk("R3 start_rec", start_rec, 1); chk("R3 drive off", spk_drive, 0); chk("R3 hiz", spk_hiz, 1);
    step(3); rec_n = 1; step(40);

    // R11 new play during end-of-message pulse
    play_edge_n = 0; step(3); play_edge_n = 1; step(3);
    eom_hit = 1; step(1); eom_hit = 0;
    chk("R11 in pulse", led_n, 0);
    play_edge_n = 0; step(3);
    chk("R11 restart", start_play, 1); chk("R11 drive", spk_drive, 1);
    play_edge_n = 1; step(3);
    mem_end = 1; step(1); mem_end = 0;
    step(4);
    chk("R12 final standby", pwr_down, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule